// File: doc/BRIEF.md
# Five-Requester Fair Bus Arbiter

This block decides which of five requesters drives a shared bus. It has one request line and one interrupt line per requester, and it drives a registered one-hot grant vector. A requester keeps the bus while it keeps requesting. Each requester has a tenure cap equal to its 1-based index: requester 1 holds at most one cycle, and requester 5 holds at most five. When several requests wait, the least recently granted requester wins. An interrupt line takes the bus on the next edge and displaces the current owner.

A recency list orders the five requesters from least recent to most recent. Reset sets the list to 1,2,3,4,5. Before any requester has been served, the list therefore gives the plain lower-index-first priority. Every new grant moves the winner to the most-recent end of the list. When an owner reaches its cap, it is barred from arbitration in that cycle. If nobody else is requesting, the grant drops to zero for one cycle and the owner is then granted again.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant_o` is zero at every rising edge, whatever the inputs are. Reset also sets the recency list to 1,2,3,4,5, with requester 1 least recent.
- R2: `grant_o` is always one-hot or all zero. Bit k-1 stands for requester k.
- R3: `grant_o` is registered. A change on `req_i` or `irq_i` shows on `grant_o` only after the next rising edge.
- R4: Right after reset, when several requesters ask together, the lowest-numbered one is granted.
- R5: The owner keeps the grant while it requests, has no competing interrupt and has held the bus fewer cycles than its index.
- R6: Requester k holds the bus for at most k consecutive cycles. On the edge where its cap is reached it is excluded from arbitration, and it can be granted again one edge later.
- R7: When the owner drops both its request and its interrupt, it loses the grant on the next edge. The pending requests are arbitrated on that same edge.
- R8: When several requests are pending, the least recently granted requester wins. Each new grant makes its winner the most recent.
- R9: When any interrupt is asserted, the lowest-numbered interrupting requester is granted on the next edge. This displaces any other owner.
- R10: A requester holding the bus through its interrupt line is still bound by its k-cycle cap.
- R11: The tenure count restarts on every new grant, including a pre-emption. The new owner gets its full k cycles.
- R12: With no request and no interrupt, the grant is zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 5 | Request lines; bit k-1 is requester k |
| irq_i | input | 5 | Interrupt (immediate take-over) lines; bit k-1 is requester k |
| grant_o | output | 5 | Registered one-hot grant; bit k-1 is requester k |

## Verification
Every grant decision is due exactly one rising edge after the inputs that cause it. The bench changes inputs on a falling edge and samples `grant_o` on the next falling edge, after exactly one rising edge. A reference model steps in lockstep and predicts that single-edge result. For R3, the bench also samples straight after changing the inputs, before any rising edge, and expects the old grant. A tenure cap of k shows as k consecutive granted samples followed by a release on the sample after them.

// File: rtl/arb_pkg.sv
// arb_pkg: shared constants for the fair bus arbiter.
// Assumes: nothing; pure constant and helper definitions.
package arb_pkg;
    localparam int unsigned ARB_PORTS = 5;

    // Width of an index able to address n requesters (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/arb_first_set.sv
// arb_first_set: finds the lowest set bit of a request vector.
// Assumes: vec is N bits wide; idx_o is only meaningful when vld_o is high.
module arb_first_set #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    // Scan from the highest bit down so that the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[k]) begin
                idx_o = IW'(k);
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_lru_order.sv
// arb_lru_order: keeps the recency list (position 0 = least recent) and picks
// the least recently granted candidate.
// Assumes: upd_idx_i < N whenever upd_i is high; the list is a permutation.
module arb_lru_order #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [IW-1:0] upd_idx_i,
    input  logic [N-1:0]  cand_i,
    output logic [IW-1:0] pick_idx_o,
    output logic          pick_vld_o
);
    logic [IW-1:0] order_q [N];
    logic [IW-1:0] order_d [N];

    // Choose the first candidate along the list, from least to most recent.
    always_comb begin
        pick_idx_o = '0;
        pick_vld_o = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (!pick_vld_o && cand_i[order_q[p]]) begin
                pick_idx_o = order_q[p];
                pick_vld_o = 1'b1;
            end
        end
    end

    // Move the new winner to the most-recent end and close up the gap behind it.
    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int p = 0; p < N; p++) order_d[p] = order_q[p];
        if (upd_i) begin
            for (int p = 0; p < N - 1; p++) begin
                if (order_q[p] == upd_idx_i) hit = 1'b1;
                if (hit) order_d[p] = order_q[p + 1];
            end
            order_d[N - 1] = upd_idx_i;
        end
    end

    // Store the list; reset gives ascending index order.
    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (!rst_n) order_q[p] <= IW'(p);
            else        order_q[p] <= order_d[p];
        end
    end

    // Every requester must appear in the list exactly once.
    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int p = 0; p < N; p++) seen[order_q[p]] = 1'b1;
    end
    a_r8_list_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {N{1'b1}});
endmodule

// File: rtl/arb_tenure.sv
// arb_tenure: counts the cycles the current owner has held the bus and flags
// when the owner has reached its cap (cap = index + 1).
// Assumes: load_i and adv_i are never high together.
module arb_tenure #(
    parameter int unsigned N  = 5,
    parameter int unsigned IW = 3,
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic          owner_vld_i,
    input  logic [IW-1:0] owner_idx_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Cap of the present owner.
    assign limit    = CW'(owner_idx_i) + CW'(1);
    assign expire_o = owner_vld_i && (cnt_q == limit);
    assign cnt_o    = cnt_q;

    // Reload on a new grant, advance while the owner continues, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= CW'(1);
        else if (adv_i)  cnt_q <= cnt_q + CW'(1);
        else             cnt_q <= '0;
    end

    a_r6_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        owner_vld_i |-> (cnt_q >= CW'(1) && cnt_q <= limit));
    a_r12_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !owner_vld_i |-> cnt_q == '0);
endmodule

// File: rtl/fair_bus_arbiter.sv
// fair_bus_arbiter: grants one shared bus to at most one of N_REQ requesters.
// The grant is registered and one-hot. Interrupts win first, lowest index.
// Otherwise the owner keeps the bus within its cap, and otherwise the least
// recently granted requester wins.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module fair_bus_arbiter #(
    parameter int unsigned N_REQ = arb_pkg::ARB_PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] irq_i,
    output logic [N_REQ-1:0] grant_o
);
    localparam int unsigned IW = arb_pkg::idx_width(N_REQ);
    localparam int unsigned CW = $clog2(N_REQ + 1);

    logic [N_REQ-1:0] grant_q, grant_d;
    logic [IW-1:0]    owner_idx_q, nx_idx;
    logic             owner_vld_q, nx_vld;
    logic             expire, hold, new_grant, cont;
    logic [N_REQ-1:0] excl, elig_irq, elig_req;
    logic [IW-1:0]    irq_idx, lru_idx;
    logic             irq_vld, lru_vld;
    logic [CW-1:0]    ten_cnt;

    // Bar the owner that has reached its cap, and see whether it may continue.
    assign excl     = grant_q & {N_REQ{expire}};
    assign elig_irq = irq_i & ~excl;
    assign elig_req = req_i & ~excl;
    assign hold     = owner_vld_q && !expire && |(grant_q & (req_i | irq_i));

    arb_first_set #(.N(N_REQ), .IW(IW)) u_irq_pick (
        .vec_i (elig_irq),
        .idx_o (irq_idx),
        .vld_o (irq_vld)
    );

    arb_lru_order #(.N(N_REQ), .IW(IW)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_i      (new_grant),
        .upd_idx_i  (nx_idx),
        .cand_i     (elig_req),
        .pick_idx_o (lru_idx),
        .pick_vld_o (lru_vld)
    );

    arb_tenure #(.N(N_REQ), .IW(IW), .CW(CW)) u_tenure (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (new_grant),
        .adv_i       (cont),
        .owner_vld_i (owner_vld_q),
        .owner_idx_i (owner_idx_q),
        .cnt_o       (ten_cnt),
        .expire_o    (expire)
    );

    // Decide the owner after the next edge: interrupt, then continuation, then LRU.
    always_comb begin
        nx_vld    = 1'b0;
        nx_idx    = owner_idx_q;
        new_grant = 1'b0;
        cont      = 1'b0;
        if (irq_vld) begin
            nx_vld = 1'b1;
            nx_idx = irq_idx;
            if (hold && irq_idx == owner_idx_q) cont = 1'b1;
            else                                new_grant = 1'b1;
        end else if (hold) begin
            nx_vld = 1'b1;
            cont   = 1'b1;
        end else if (lru_vld) begin
            nx_vld    = 1'b1;
            nx_idx    = lru_idx;
            new_grant = 1'b1;
        end
        grant_d = '0;
        if (nx_vld) grant_d[nx_idx] = 1'b1;
    end

    // Register the grant and the owner index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q     <= '0;
            owner_idx_q <= '0;
            owner_vld_q <= 1'b0;
        end else begin
            grant_q     <= grant_d;
            owner_idx_q <= nx_idx;
            owner_vld_q <= nx_vld;
        end
    end

    assign grant_o = grant_q;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> grant_q == '0);
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q) && (owner_vld_q == |grant_q));
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && irq_i == '0) |=> grant_q == '0);
    a_r9_top_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[0] && !grant_q[0]) |=> grant_q[0]);
    a_r11_preempt_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[0] && !grant_q[0]) |=> ten_cnt == CW'(1));

    for (genvar k = 0; k < N_REQ; k++) begin : g_owner_checks
        a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[k] && req_i[k] && irq_i == '0 && ten_cnt < CW'(k + 1)) |=> grant_q[k]);
        a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_q[k] && !req_i[k] && !irq_i[k]) |=> !grant_q[k]);
    end
endmodule

// File: tb/fair_bus_arbiter_bench.sv
// fair_bus_arbiter_bench: directed scenarios checked against an in-bench model
// of the requirements, plus hand-computed expectations at key points.
module fair_bus_arbiter_bench;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] irq = '0;
    logic [N-1:0] grant;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int m_owner;
    int m_cnt;
    int m_ord [N];

    fair_bus_arbiter #(.N_REQ(N)) u_fair_bus_arbiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .irq_i   (irq),
        .grant_o (grant)
    );

    always #2 clk = ~clk;

    // End a hung run as a failure.
    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_grant();
        logic [N-1:0] g;
        g = '0;
        if (m_owner >= 0) g[m_owner] = 1'b1;
        return g;
    endfunction

    task automatic model_reset();
        m_owner = -1;
        m_cnt   = 0;
        for (int p = 0; p < N; p++) m_ord[p] = p;
    endtask

    task automatic model_new(input int w);
        int pos;
        pos = 0;
        for (int p = 0; p < N; p++) if (m_ord[p] == w) pos = p;
        for (int p = pos; p < N - 1; p++) m_ord[p] = m_ord[p + 1];
        m_ord[N - 1] = w;
        m_owner = w;
        m_cnt   = 1;
    endtask

    // One arbitration step of the model, from the present inputs.
    task automatic model_step();
        bit ex, hold;
        logic [N-1:0] ei, er;
        int w;
        ex   = (m_owner >= 0) && (m_cnt == m_owner + 1);
        hold = (m_owner >= 0) && !ex && (req[m_owner] || irq[m_owner]);
        ei = irq;
        er = req;
        if (ex) begin
            ei[m_owner] = 1'b0;
            er[m_owner] = 1'b0;
        end
        if (ei != '0) begin
            w = -1;
            for (int k = N - 1; k >= 0; k--) if (ei[k]) w = k;
            if (hold && w == m_owner) m_cnt++;
            else model_new(w);
        end else if (hold) begin
            m_cnt++;
        end else if (er != '0) begin
            w = -1;
            for (int p = N - 1; p >= 0; p--) if (er[m_ord[p]]) w = m_ord[p];
            model_new(w);
        end else begin
            m_owner = -1;
            m_cnt   = 0;
        end
    endtask

    // Advance one edge and compare against the model; also the one-hot rule (R2).
    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, grant, model_grant());
        checks++;
        if ($countones(grant) > 1) begin
            errors++;
            $display("FAIL R2: actual=%b expected=one-hot or zero", grant);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '1;
        irq = '1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1", grant, '0);
        end
        req = '0;
        irq = '0;
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        do_reset();
        for (int c = 0; c < 3; c++) step("R12");
        check("R12", grant, 5'b00000);
    endtask

    task automatic t_fixed_order();
        do_reset();
        req = 5'b11111;
        step("R4");
        check("R4", grant, 5'b00001);
        req = 5'b11110;
        step("R4");
        check("R4", grant, 5'b00010);
    endtask

    task automatic t_registered();
        do_reset();
        req = 5'b00100;
        step("R5");
        req = 5'b00000;
        irq = 5'b00001;
        #1;
        check("R3", grant, 5'b00100);
        step("R3");
        check("R3", grant, 5'b00001);
        irq = '0;
        step("R12");
    endtask

    task automatic t_hold_and_cap();
        do_reset();
        req = 5'b10000;
        for (int c = 0; c < 5; c++) begin
            step("R5");
            check("R5", grant, 5'b10000);
        end
        step("R6");
        check("R6", grant, 5'b00000);
        step("R6");
        check("R6", grant, 5'b10000);
        req = 5'b00001;
        step("R6");
        step("R6");
        check("R6", grant, 5'b00000);
    endtask

    task automatic t_drop();
        do_reset();
        req = 5'b01010;
        step("R7");
        check("R7", grant, 5'b00010);
        req = 5'b01000;
        step("R7");
        check("R7", grant, 5'b01000);
        req = 5'b00000;
        step("R7");
    endtask

    task automatic t_lru();
        do_reset();
        req = 5'b00110;
        for (int c = 0; c < 6; c++) step("R8");
        req = 5'b11111;
        for (int c = 0; c < 20; c++) step("R8");
        req = 5'b10101;
        for (int c = 0; c < 12; c++) step("R8");
        req = 5'b01011;
        for (int c = 0; c < 12; c++) step("R8");
    endtask

    task automatic t_irq();
        do_reset();
        req = 5'b10000;
        step("R9");
        step("R9");
        irq = 5'b01100;
        step("R9");
        check("R9", grant, 5'b00100);
        irq = 5'b00000;
        req = 5'b10100;
        for (int c = 0; c < 6; c++) step("R9");
    endtask

    task automatic t_irq_cap();
        do_reset();
        irq = 5'b00010;
        step("R10");
        check("R10", grant, 5'b00010);
        step("R10");
        step("R10");
        check("R10", grant, 5'b00000);
        step("R10");
        check("R10", grant, 5'b00010);
        irq = '0;
        step("R12");
    endtask

    task automatic t_reload();
        do_reset();
        req = 5'b11000;
        step("R11");
        step("R11");
        step("R11");
        irq = 5'b01000;
        step("R11");
        check("R11", grant, 5'b01000);
        irq = '0;
        req = 5'b01000;
        for (int c = 0; c < 5; c++) step("R11");
        req = '0;
        step("R12");
    endtask

    initial begin
        model_reset();
        t_idle();
        t_fixed_order();
        t_registered();
        t_hold_and_cap();
        t_drop();
        t_lru();
        t_irq();
        t_irq_cap();
        t_reload();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule